// File: doc/BRIEF.md
# Serial SAR converter frame controller

The block sits on the host side of a 12-bit successive-approximation converter. That converter is started by a rising edge on a dedicated start line and is read over a serial clock/data pair. A one-cycle `start_i` request in the idle state opens a frame. The block first drives the start strobe high for a programmable number of clocks. It then waits out the conversion time and runs a burst of twelve serial clocks. During the burst it shifts a 6-bit setup word into the converter and shifts the new 12-bit sample out of it. The sample appears on `data_o` with a one-cycle `valid_o` pulse.

The setup word sent in a frame configures the conversion that the next frame starts, so the read path is pipelined by one frame. The sample of the first frame after reset was taken with an unknown setup and is flagged as unusable. The converter begins to track its input once the sixth setup bit has been clocked in. The block therefore enforces a minimum track time, given in nanoseconds and converted to system clocks, between that edge and the next start strobe. Start requests that arrive while a frame or the track interval is in progress are dropped.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is held, `busy_o`, `adc_convst_o`, `adc_sck_o`, `adc_sdi_o`, `valid_o`, `data_ok_o` and `data_o` are all low.
- R2: A `start_i` high in an idle cycle drives `adc_convst_o` high in the following cycle, for exactly START_CYC cycles. A `start_i` seen while `busy_o` is high has no effect on any output.
- R3: After the strobe falls, CONV_CYC cycles pass with `adc_sck_o` low. Then 12 serial clock periods follow, each SCK_LO_CYC cycles low and then SCK_HI_CYC cycles high. Outside this burst `adc_sck_o` stays low.
- R4: The setup word goes out on `adc_sdi_o` MSB first and changes only while the serial clock is low. Bit 5 is single-ended select (`se_i`), bit 4 is odd-channel/sign select (`odd_i`), bits 3 and 2 are 0, bit 1 is unipolar select (`uni_i`) and bit 0 is sleep request (`sleep_i`). During the last six serial clocks the line is 0.
- R5: `adc_sdo_i` is sampled on each rising serial clock, first bit into `data_o[11]`. `data_o` updates, and `valid_o` is high for one cycle, in the cycle after the twelfth falling serial clock.
- R6: `data_ok_o` is 0 with the first `valid_o` after reset and 1 with every later one.
- R7: At least ACQ_CYC = ceil(ACQ_NS * CLK_HZ / 1e9) clock edges separate the sixth rising serial clock of a frame from the next rising edge of `adc_convst_o`.
- R8: `busy_o` is high from the strobe's first cycle until the block returns to idle. It goes low in the cycle after both the burst has ended and R7 is satisfied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | frame request |
| se_i | input | 1 | single-ended select for next conversion |
| odd_i | input | 1 | odd channel / sign select |
| uni_i | input | 1 | unipolar select |
| sleep_i | input | 1 | sleep request after next conversion |
| busy_o | output | 1 | frame or track interval in progress |
| data_o | output | 12 | last captured sample |
| valid_o | output | 1 | one-cycle sample strobe |
| data_ok_o | output | 1 | sample came from a configured conversion |
| adc_convst_o | output | 1 | conversion start strobe |
| adc_sck_o | output | 1 | serial clock to converter |
| adc_sdi_o | output | 1 | setup data to converter |
| adc_sdo_i | input | 1 | sample data from converter |

## Verification
The bench builds the block at 125 MHz with a 240 ns track time, which gives 30 cycles. It uses a 2-cycle strobe, a 5-cycle conversion wait and a serial clock of one cycle low and one cycle high. With these values the burst after the sixth rising edge lasts far less than the track time, so the acquire state must hold the block busy. Holding `start_i` high across frames then places every strobe exactly on the track-time boundary. The short conversion wait keeps a frame near fifty cycles, so many setup words and samples fit in a short run.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int CFG_W  = 6;
  localparam int DATA_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_CONVERT,
    ST_SHIFT,
    ST_ACQUIRE
  } sar_state_e;

  typedef struct packed {
    logic single_ended;
    logic odd_sel;
    logic unipolar;
    logic sleep;
  } sar_cfg_t;

  function automatic logic [CFG_W-1:0] pack_cfg(input sar_cfg_t c);
    return {c.single_ended, c.odd_sel, 2'b00, c.unipolar, c.sleep};
  endfunction
endpackage

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sar_sck_gen.sv
module sar_sck_gen #(
  parameter int LO_CYC = 1,
  parameter int HI_CYC = 1,
  parameter int NBITS  = 12,
  parameter int BIT_W  = $clog2(NBITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             last_o,
  output logic [BIT_W-1:0] bit_idx_o
);
  localparam int PH_MAX = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  logic             sck_q;
  logic [PH_W-1:0]  ph_q;
  logic [BIT_W-1:0] bit_q;

  assign rise_o    = run_i && !sck_q && (ph_q == PH_W'(LO_CYC - 1));
  assign fall_o    = run_i &&  sck_q && (ph_q == PH_W'(HI_CYC - 1));
  assign last_o    = fall_o && (bit_q == BIT_W'(NBITS - 1));
  assign sck_o     = sck_q;
  assign bit_idx_o = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
    end else if (!run_i) begin
      sck_q <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
    end else if (rise_o) begin
      sck_q <= 1'b1;
      ph_q  <= '0;
    end else if (fall_o) begin
      sck_q <= 1'b0;
      ph_q  <= '0;
      bit_q <= bit_q + 1'b1;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end

  assert_sck_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sck_o);

  assert_high_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && run_i) |-> (ph_q < PH_W'(HI_CYC)));
endmodule

// File: rtl/sar_shifter.sv
module sar_shifter #(
  parameter int CFG_W  = 6,
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CFG_W-1:0]  word_i,
  input  logic              shift_out_i,
  input  logic              shift_in_i,
  input  logic              sdo_i,
  output logic              sdi_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int PAD_W = DATA_W - CFG_W;

  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] tx_init;

  generate
    if (PAD_W > 0) begin : g_pad
      assign tx_init = {word_i, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign tx_init = word_i[CFG_W-1 -: DATA_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= tx_init;
      rx_q <= '0;
    end else begin
      if (shift_out_i) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      if (shift_in_i)  rx_q <= {rx_q[DATA_W-2:0], sdo_i};
    end
  end

  assign sdi_o = tx_q[DATA_W-1];
  assign rx_o  = rx_q;

  assert_no_dual_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !(shift_out_i || shift_in_i));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int CLK_HZ     = 125_000_000,
  parameter int ACQ_NS     = 240,
  parameter int START_CYC  = 2,
  parameter int CONV_CYC   = 200,
  parameter int SCK_LO_CYC = 3,
  parameter int SCK_HI_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              se_i,
  input  logic              odd_i,
  input  logic              uni_i,
  input  logic              sleep_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              data_ok_o,
  output logic              adc_convst_o,
  output logic              adc_sck_o,
  output logic              adc_sdi_o,
  input  logic              adc_sdo_i
);
  localparam longint ACQ_RAW = (longint'(CLK_HZ) * ACQ_NS + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int ACQ_CYC = (ACQ_RAW < 1) ? 1 : int'(ACQ_RAW);
  localparam int ACQ_W   = $clog2(ACQ_CYC + 1);
  localparam int TMR_MAX = (START_CYC > CONV_CYC) ? START_CYC : CONV_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int BIT_W   = $clog2(DATA_W + 1);

  sar_state_e        state_q;
  logic              convst_q, valid_q, ok_q, primed_q;
  logic [DATA_W-1:0] data_q;
  logic [ACQ_W-1:0]  acq_q;
  logic              acq_ok;

  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;

  logic              sck_run, sck_rise, sck_fall, sck_last;
  logic [BIT_W-1:0]  bit_idx;

  logic              sh_load;
  logic [DATA_W-1:0] rx_word;
  sar_cfg_t          cfg;

  assign cfg = '{single_ended: se_i, odd_sel: odd_i, unipolar: uni_i, sleep: sleep_i};

  assign tmr_load = (state_q == ST_IDLE && start_i) || (state_q == ST_START && tmr_zero);
  assign tmr_val  = (state_q == ST_IDLE) ? TMR_W'(START_CYC - 1) : TMR_W'(CONV_CYC - 1);
  assign sh_load  = (state_q == ST_CONVERT) && tmr_zero;
  assign sck_run  = (state_q == ST_SHIFT);
  assign acq_ok   = (acq_q >= ACQ_W'(ACQ_CYC));

  sar_timer #(.W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sar_sck_gen #(
    .LO_CYC (SCK_LO_CYC),
    .HI_CYC (SCK_HI_CYC),
    .NBITS  (DATA_W),
    .BIT_W  (BIT_W)
  ) u_sck (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (sck_run),
    .sck_o     (adc_sck_o),
    .rise_o    (sck_rise),
    .fall_o    (sck_fall),
    .last_o    (sck_last),
    .bit_idx_o (bit_idx)
  );

  sar_shifter #(.CFG_W(CFG_W), .DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (sh_load),
    .word_i      (pack_cfg(cfg)),
    .shift_out_i (sck_fall),
    .shift_in_i  (sck_rise),
    .sdo_i       (adc_sdo_i),
    .sdi_o       (adc_sdi_o),
    .rx_o        (rx_word)
  );

  // track interval opens at the rising edge that clocks in the last setup bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         acq_q <= ACQ_W'(ACQ_CYC);
    else if (sck_rise && bit_idx == BIT_W'(CFG_W - 1))   acq_q <= ACQ_W'(1);
    else if (!acq_ok)                                    acq_q <= acq_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      convst_q <= 1'b0;
      valid_q  <= 1'b0;
      ok_q     <= 1'b0;
      primed_q <= 1'b0;
      data_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_START;
          convst_q <= 1'b1;
        end
        ST_START: if (tmr_zero) begin
          state_q  <= ST_CONVERT;
          convst_q <= 1'b0;
        end
        ST_CONVERT: if (tmr_zero) state_q <= ST_SHIFT;
        ST_SHIFT: if (sck_last) begin
          state_q  <= ST_ACQUIRE;
          data_q   <= rx_word;
          valid_q  <= 1'b1;
          ok_q     <= primed_q;
          primed_q <= 1'b1;
        end
        ST_ACQUIRE: if (acq_ok) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign adc_convst_o = convst_q;
  assign valid_o      = valid_q;
  assign data_o       = data_q;
  assign data_ok_o    = ok_q;

  // independent observer of the serial lines for the track-time check
  localparam int RC_W = $clog2(DATA_W + 2);
  logic             chk_sck_d;
  logic [RC_W-1:0]  chk_rises;
  logic [ACQ_W-1:0] chk_since;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_sck_d <= 1'b0;
      chk_rises <= '0;
      chk_since <= ACQ_W'(ACQ_CYC);
    end else begin
      chk_sck_d <= adc_sck_o;
      if (adc_convst_o) chk_rises <= '0;
      else if (adc_sck_o && !chk_sck_d) chk_rises <= chk_rises + 1'b1;
      if (adc_sck_o && !chk_sck_d && chk_rises == RC_W'(CFG_W - 1)) chk_since <= ACQ_W'(1);
      else if (chk_since < ACQ_W'(ACQ_CYC)) chk_since <= chk_since + 1'b1;
    end
  end

  assert_strobe_on_request_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_convst_o) |-> ($past(start_i) && $past(!busy_o)));

  assert_sck_in_burst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_sck_o |-> (busy_o && !adc_convst_o));

  assert_sdi_stable_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_sck_o && $past(adc_sck_o)) |-> $stable(adc_sdi_o));

  assert_sdi_tail_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_sck_o && chk_rises > RC_W'(CFG_W)) |-> !adc_sdi_o);

  assert_valid_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_track_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_convst_o) |-> (chk_since >= ACQ_W'(ACQ_CYC)));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!adc_sck_o && !adc_convst_o && !valid_o));
endmodule

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
  import sar_adc_pkg::*;

  localparam int CLK_HZ = 125_000_000;
  localparam int ACQ_NS = 240;
  localparam int S  = 2;
  localparam int C  = 5;
  localparam int L  = 1;
  localparam int H  = 1;
  localparam int NB = 12;
  localparam int A  = (ACQ_NS * (CLK_HZ / 1_000_000) + 999) / 1000;
  localparam int P  = L + H;
  localparam int T0 = S + C;
  localparam int END_BURST = T0 + NB * P;
  localparam int END_ACQ   = T0 + 5 * P + L + A - 1;
  localparam int IDLE_T    = ((END_BURST > END_ACQ) ? END_BURST : END_ACQ) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, se = 1'b0, odd = 1'b0, uni = 1'b0, slp = 1'b0;
  logic busy, valid, data_ok, convst, sck, sdi;
  logic sdo = 1'b0;
  logic [11:0] data;

  always #4 clk = ~clk;

  sar_adc_ctrl #(
    .CLK_HZ(CLK_HZ), .ACQ_NS(ACQ_NS), .START_CYC(S), .CONV_CYC(C),
    .SCK_LO_CYC(L), .SCK_HI_CYC(H)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .se_i(se), .odd_i(odd), .uni_i(uni), .sleep_i(slp),
    .busy_o(busy), .data_o(data), .valid_o(valid), .data_ok_o(data_ok),
    .adc_convst_o(convst), .adc_sck_o(sck), .adc_sdi_o(sdi), .adc_sdo_i(sdo)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // timeline model: cycle index inside the current frame, -1 when idle
  int m_t = -1;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) m_t = -1;
    else if (m_t >= 0) begin
      m_t++;
      if (m_t >= IDLE_T) m_t = -1;
    end else if (start) m_t = 0;
  end

  // converter model
  int          adc_k = 0;
  int          adc_nb = 0;
  int          rise6_cyc = -1;
  logic [5:0]  adc_cfg = '0;
  logic [5:0]  adc_rx = '0;
  logic [11:0] adc_out = '0;
  logic [11:0] exp_q[$];
  int          n_valid = 0;

  function automatic logic [5:0] exp_word();
    return {se, odd, 2'b00, uni, slp};
  endfunction

  always @(posedge convst) begin
    if (rise6_cyc >= 0)
      chk((cyc - rise6_cyc) >= A, "R7", "edges from 6th sck rise to strobe", cyc - rise6_cyc, A);
    adc_out = {adc_cfg, 6'(adc_k)};
    exp_q.push_back(adc_out);
    sdo = adc_out[11];
    adc_nb = 0;
    adc_k++;
  end

  always @(posedge sck) begin
    if (adc_nb < 6) adc_rx = {adc_rx[4:0], sdi};
    else chk(sdi == 1'b0, "R4", "sdi after setup word", int'(sdi), 0);
    adc_nb++;
    if (adc_nb == 6) begin
      adc_cfg = adc_rx;
      rise6_cyc = cyc;
      chk(adc_rx == exp_word(), "R4", "setup word received", int'(adc_rx), int'(exp_word()));
    end
  end

  always @(negedge sck) begin
    adc_out = adc_out << 1;
    sdo = adc_out[11];
  end

  // per-cycle comparison against the model
  bit cmp_en = 1'b0;
  always @(negedge clk) begin
    if (cmp_en) begin
      automatic int u = m_t - T0;
      automatic logic e_busy = (m_t >= 0);
      automatic logic e_cst  = (m_t >= 0) && (m_t < S);
      automatic logic e_sck  = (m_t >= 0) && (u >= 0) && (u < NB * P) && ((u % P) >= L);
      automatic logic e_val  = (m_t == END_BURST);
      chk(busy == e_busy, "R8", "busy_o", int'(busy), int'(e_busy));
      chk(convst == e_cst, "R2", "adc_convst_o", int'(convst), int'(e_cst));
      chk(sck == e_sck, "R3", "adc_sck_o", int'(sck), int'(e_sck));
      chk(valid == e_val, "R5", "valid_o", int'(valid), int'(e_val));
      if (valid && exp_q.size() > 0) begin
        automatic logic [11:0] e = exp_q.pop_front();
        chk(data == e, "R5", "data_o", int'(data), int'(e));
        chk(data_ok == (n_valid > 0), "R6", "data_ok_o", int'(data_ok), int'(n_valid > 0));
        n_valid++;
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  task automatic set_cfg(input logic a, input logic b, input logic c, input logic d);
    se = a; odd = b; uni = c; slp = d;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, convst, sck, sdi, valid, data_ok} == 6'b0, "R1", "control outputs in reset",
        int'({busy, convst, sck, sdi, valid, data_ok}), 0);
    chk(data == 12'd0, "R1", "data_o in reset", int'(data), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    repeat (2) @(negedge clk);

    // single frames, with extra requests during busy (R2 hold-off)
    for (int f = 0; f < 5; f++) begin
      set_cfg(f[0], f[1], ~f[0], f[2]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      start = 1'b1;           // R2: ignored, strobe active
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      start = 1'b1;           // R2: ignored, burst or track interval
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);
    end

    // back-to-back frames: strobe lands on the R7 boundary
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0);
    start = 1'b1;
    repeat (4 * IDLE_T) @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);

    chk(n_valid >= 8, "R5", "number of samples delivered", n_valid, 8);
    summary();
    $finish;
  end
endmodule